// File: doc/BRIEF.md
# USB Line-State Framer

This block watches the two wires of a low-speed or full-speed USB link with a sample clock that runs several times faster than the bit rate. Each sample of the pair is turned into one of four line states: J, K, single-ended zero (SE0) or single-ended one (SE1). A speed input picks which of the two differential patterns means J and which means K. It also picks the length of the bit cell used for sampling.

The line rests in J between packets. A change into K starts a packet. From that edge a fixed-point phase accumulator places one sample point in the middle of every bit cell. The fractional part of the accumulator keeps a non-integer bit length from drifting over a long packet. Each sampled line state goes out on a one-cycle strobe. A sampled SE0 followed at the next sample point by J ends the packet, and the block then waits in idle for the next start. NRZI decoding and bit unstuffing belong to the stage downstream.

Top module: `usb_line_framer`

## Requirements
- R1: Line states are coded on `sym_o` as 00 = SE0, 01 = J, 10 = K, 11 = SE1. With `low_speed_i` low, (dp,dm) = (1,0) is J and (0,1) is K. With `low_speed_i` high these two are swapped. (0,0) is SE0 and (1,1) is SE1 at both speeds.
- R2: In idle, a change of the line into K raises `sop_o` for exactly one cycle and raises `in_packet_o`. Both become visible after the third rising clock edge that follows the change on the pins.
- R3: In idle, line states other than K (J, SE0, SE1) produce no `sop_o`, no `sym_valid_o` and no `eop_o`, and `in_packet_o` stays low.
- R4: The bit length P is a parameter in 16.8 fixed point, one for each speed. Take the cycle in which `sop_o` is high as offset 0. Sample n (n = 0, 1, ...) is then presented at offset floor((P/2 + n*P)/256) cycles.
- R5: Each sample point raises `sym_valid_o` for one cycle with the sampled code on `sym_o`. Sample 0 is the K of the start edge. SE1 inside a packet is forwarded like any other state and does not end the packet.
- R6: A sampled SE0 followed by a sampled J at the next sample point ends the packet. `eop_o` is high for one cycle together with the `sym_valid_o` of that J, and `in_packet_o` is low in that same cycle. A single SE0 bit is enough.
- R7: A sampled SE0 followed by K or by another SE0 does not end the packet, and sampling continues at the same cadence.
- R8: After the end of a packet the block is idle again. The next change into K starts a new packet whose sample timing counts from its own start edge.
- R9: While `rst_ni` is low, `sop_o`, `eop_o`, `sym_valid_o` and `in_packet_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Positive data line, asynchronous |
| dm_i | input | 1 | Negative data line, asynchronous |
| low_speed_i | input | 1 | 1 = low-speed polarity and bit length, 0 = full-speed; held steady |
| sop_o | output | 1 | One-cycle start-of-packet pulse |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| sym_valid_o | output | 1 | Strobe for a sampled line state |
| sym_o | output | 2 | Sampled line state code |
| in_packet_o | output | 1 | High between start and end of packet |

## Verification
The bench uses bit lengths of 4.5 and 8.25 samples, so the sample spacing has to alternate, for example 4,5,4,5 cycles. A design that drops the fraction would drift off the middle of the cell and pick up the wrong line state late in the packet. Both speeds carry the same logical states on opposite pin patterns, so a design with fixed polarity would report J and K swapped at one of them. The bench sends a single-SE0 end, an SE0 followed by K, and an SE1 inside a packet. A framer that needs two SE0 bits, that ends on any SE0, or that treats SE1 as an end would show the wrong `eop_o` count or cycle. Noise in idle and a second packet right after an end check that only a change into K starts a packet and that the timing is counted again from the new start edge.

// File: rtl/usb_lf_pkg.sv
package usb_lf_pkg;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BIT  = 2'b01,
    ST_END  = 2'b10
  } frm_state_e;

endpackage

// File: rtl/usb_lf_sync.sv
module usb_lf_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/usb_lf_classify.sv
module usb_lf_classify
  import usb_lf_pkg::*;
(
  input  logic      dp_i,
  input  logic      dm_i,
  input  logic      low_speed_i,
  output line_sym_e sym_o
);

  always_comb begin
    unique case ({dp_i, dm_i})
      2'b00:   sym_o = SYM_SE0;
      2'b11:   sym_o = SYM_SE1;
      2'b10:   sym_o = low_speed_i ? SYM_K : SYM_J;
      default: sym_o = low_speed_i ? SYM_J : SYM_K;
    endcase
  end

endmodule

// File: rtl/usb_lf_phase.sv
// Remaining distance to the next cell centre, in 1/2^FRAC_W sample units.
module usb_lf_phase #(
  parameter int unsigned PER_W  = 24,
  parameter int unsigned FRAC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);

  localparam int unsigned ACC_W = PER_W + 1;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] rem_q, per_x, half_x, base;

  assign per_x  = {1'b0, period_i};
  assign half_x = per_x >> 1;
  assign tick_o = run_i && (rem_q < ONE);
  assign base   = tick_o ? rem_q + per_x : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (start_i) rem_q <= half_x - ONE;
    else if (run_i)   rem_q <= base - ONE;
  end

endmodule

// File: rtl/usb_line_framer.sv
module usb_line_framer
  import usb_lf_pkg::*;
#(
  parameter int unsigned INT_W       = 16,
  parameter int unsigned FRAC_W      = 8,
  parameter int unsigned FS_PERIOD   = 1024,  // 4.0 samples per bit
  parameter int unsigned LS_PERIOD   = 8192,  // 32.0 samples per bit
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       low_speed_i,
  output logic       sop_o,
  output logic       eop_o,
  output logic       sym_valid_o,
  output logic [1:0] sym_o,
  output logic       in_packet_o
);

  localparam int unsigned PER_W = INT_W + FRAC_W;
  localparam logic [PER_W-1:0] FS_P = PER_W'(FS_PERIOD);
  localparam logic [PER_W-1:0] LS_P = PER_W'(LS_PERIOD);

  logic [1:0] line_s;
  line_sym_e  cur_sym, prev_sym_q, last_samp_q;
  frm_state_e state_q;
  logic       sop_det, tick, run;
  logic [PER_W-1:0] period;
  logic       sop_q, eop_q, vld_q;
  line_sym_e  sym_q;

  usb_lf_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dp_i, dm_i}),
    .q_o   (line_s)
  );

  usb_lf_classify u_cls (
    .dp_i       (line_s[1]),
    .dm_i       (line_s[0]),
    .low_speed_i(low_speed_i),
    .sym_o      (cur_sym)
  );

  assign period  = low_speed_i ? LS_P : FS_P;
  assign run     = (state_q != ST_IDLE);
  // only a change into K counts in idle
  assign sop_det = (state_q == ST_IDLE) && (cur_sym == SYM_K) && (prev_sym_q != SYM_K);

  usb_lf_phase #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sop_det),
    .run_i   (run),
    .period_i(period),
    .tick_o  (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      prev_sym_q  <= SYM_J;
      last_samp_q <= SYM_J;
      sop_q       <= 1'b0;
      eop_q       <= 1'b0;
      vld_q       <= 1'b0;
      sym_q       <= SYM_J;
    end else begin
      prev_sym_q <= cur_sym;
      sop_q      <= 1'b0;
      eop_q      <= 1'b0;
      vld_q      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sop_det) begin
            state_q <= ST_BIT;
            sop_q   <= 1'b1;
          end
        end
        ST_BIT: begin
          if (tick) begin
            vld_q       <= 1'b1;
            sym_q       <= cur_sym;
            last_samp_q <= cur_sym;
            if (cur_sym == SYM_SE0) state_q <= ST_END;
          end
        end
        ST_END: begin
          if (tick) begin
            vld_q       <= 1'b1;
            sym_q       <= cur_sym;
            last_samp_q <= cur_sym;
            if (cur_sym == SYM_J && last_samp_q == SYM_SE0) begin
              eop_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sop_o       = sop_q;
  assign eop_o       = eop_q;
  assign sym_valid_o = vld_q;
  assign sym_o       = sym_q;
  assign in_packet_o = (state_q != ST_IDLE);

endmodule

// File: rtl/usb_lf_checker.sv
module usb_lf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sop_o,
  input logic       eop_o,
  input logic       sym_valid_o,
  input logic [1:0] sym_o,
  input logic       in_packet_o
);

  assert_sop_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |=> !sop_o);

  assert_sop_enters_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> in_packet_o);

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_packet_o && !eop_o) |-> !sym_valid_o);

  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |=> !sym_valid_o);

  assert_eop_on_j_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (sym_valid_o && sym_o == 2'b01));

  assert_eop_leaves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (!in_packet_o && $past(in_packet_o)));

  assert_no_sop_eop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sop_o && eop_o));

endmodule

bind usb_line_framer usb_lf_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sop_o      (sop_o),
  .eop_o      (eop_o),
  .sym_valid_o(sym_valid_o),
  .sym_o      (sym_o),
  .in_packet_o(in_packet_o)
);

// File: tb/usb_line_framer_test.sv
module usb_line_framer_test;

  localparam int CLK_PERIOD = 10;
  localparam int FS_P = 1152;  // 4.5
  localparam int LS_P = 2112;  // 8.25
  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b1, dm = 1'b0, ls = 1'b0;
  logic sop, eop, vld, inpkt;
  logic [1:0] sym;

  int n_chk = 0, n_fail = 0;
  int cyc, sop_n, sop_cyc, sym_n, eop_n, eop_cyc, wd;
  logic [1:0] got_sym [64];
  int got_cyc [64];
  logic [1:0] cells [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_line_framer #(.FS_PERIOD(FS_P), .LS_PERIOD(LS_P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dp_i(dp), .dm_i(dm), .low_speed_i(ls),
    .sop_o(sop), .eop_o(eop), .sym_valid_o(vld), .sym_o(sym), .in_packet_o(inpkt)
  );

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    cyc++;
    if (sop) begin sop_n++; sop_cyc = cyc; end
    if (vld) begin
      if (sym_n < 64) begin got_sym[sym_n] = sym; got_cyc[sym_n] = cyc; end
      sym_n++;
    end
    if (eop) begin eop_n++; eop_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] lines(input logic [1:0] s, input logic low);
    case (s)
      SE0: return 2'b00;
      SE1: return 2'b11;
      J:   return low ? 2'b01 : 2'b10;
      default: return low ? 2'b10 : 2'b01;
    endcase
  endfunction

  task automatic clear_mon();
    cyc = 0; sop_n = 0; sop_cyc = 0; sym_n = 0; eop_n = 0; eop_cyc = 0;
  endtask

  task automatic idle_j(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {dp, dm} = lines(J, ls);
    end
  endtask

  task automatic set_speed(input logic low);
    for (int i = 0; i < 4; i++) begin @(negedge clk); {dp, dm} = 2'b00; end
    ls = low;
    idle_j(6);
  endtask

  task automatic drive_pkt(input int n, input int tail);
    int p, c;
    p = ls ? LS_P : FS_P;
    c = 0;
    @(negedge clk);
    clear_mon();
    while ((c * 256) / p < n) begin
      {dp, dm} = lines(cells[(c * 256) / p], ls);
      c++;
      @(negedge clk);
    end
    {dp, dm} = lines(J, ls);
    idle_j(tail);
  endtask

  task automatic check_pkt(input int n);
    int p, off;
    p = ls ? LS_P : FS_P;
    chk(sop_n == 1, "R2 sop count", sop_n, 1);
    chk(sop_cyc == 3, "R2 sop latency", sop_cyc, 3);
    chk(sym_n == n, "R5 sample count", sym_n, n);
    for (int i = 0; i < n && i < 64; i++) begin
      off = ((p / 2) + i * p) / 256;
      chk(got_sym[i] == cells[i], "R1 sampled code", int'(got_sym[i]), int'(cells[i]));
      chk(got_cyc[i] - sop_cyc == off, "R4 sample offset", got_cyc[i] - sop_cyc, off);
    end
    chk(eop_n == 1, "R6 eop count", eop_n, 1);
    chk(eop_cyc == got_cyc[n-1], "R6 eop cycle", eop_cyc, got_cyc[n-1]);
    chk(inpkt == 1'b0, "R8 idle after eop", int'(inpkt), 0);
  endtask

  task automatic t_reset();
    #(CLK_PERIOD/4);
    chk({sop, eop, vld, inpkt} == 4'b0, "R9 reset outputs", int'({sop, eop, vld, inpkt}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_j(6);
    chk(inpkt == 1'b0, "R9 idle after reset", int'(inpkt), 0);
  endtask

  task automatic t_fs_packet();
    cells[0] = K; cells[1] = J; cells[2] = K; cells[3] = K; cells[4] = J;
    cells[5] = J; cells[6] = SE0; cells[7] = SE0; cells[8] = J;
    drive_pkt(9, 20);
    check_pkt(9);
  endtask

  task automatic t_back_to_back();
    // R8: new packet straight after the previous end
    cells[0] = K; cells[1] = K; cells[2] = J; cells[3] = SE0; cells[4] = SE0; cells[5] = J;
    drive_pkt(6, 12);
    check_pkt(6);
  endtask

  task automatic t_ls_packet();
    set_speed(1'b1);
    cells[0] = K; cells[1] = J; cells[2] = SE1; cells[3] = K; cells[4] = J;
    cells[5] = SE0; cells[6] = J;
    drive_pkt(7, 30);
    check_pkt(7);  // R1 polarity swap, R5 SE1 forwarded
    set_speed(1'b0);
  endtask

  task automatic t_single_se0();
    cells[0] = K; cells[1] = J; cells[2] = SE0; cells[3] = J;
    drive_pkt(4, 20);
    check_pkt(4);  // R6 one SE0 bit
  endtask

  task automatic t_se0_not_j();
    cells[0] = K; cells[1] = SE0; cells[2] = K; cells[3] = J; cells[4] = SE0;
    cells[5] = SE0; cells[6] = J;
    drive_pkt(7, 20);
    check_pkt(7);  // R7 eop only at the final SE0,J
  endtask

  task automatic t_idle_noise();
    @(negedge clk);
    clear_mon();
    for (int i = 0; i < 5; i++) begin {dp, dm} = 2'b00; @(negedge clk); end
    for (int i = 0; i < 5; i++) begin {dp, dm} = 2'b11; @(negedge clk); end
    idle_j(10);
    chk(sop_n == 0, "R3 no sop on noise", sop_n, 0);
    chk(sym_n == 0, "R3 no strobe on noise", sym_n, 0);
    chk(eop_n == 0, "R3 no eop on noise", eop_n, 0);
    chk(inpkt == 1'b0, "R3 stays idle", int'(inpkt), 0);
  endtask

  initial begin
    clear_mon();
    t_reset();
    t_idle_noise();
    t_fs_packet();
    t_back_to_back();
    t_single_se0();
    t_se0_not_j();
    t_ls_packet();
    t_fs_packet();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

endmodule